// File: doc/BRIEF.md
# Two-Level Nested Interrupt Priority Controller

The controller decides which of five maskable interrupt sources gets serviced, and when. It also decides whether a service already running may be interrupted. Each source has a fixed default rank: source 0 ranks highest and source 4 lowest. A small configuration register holds two things: a global interrupt enable and a 3-bit code. The code can promote exactly one source to high priority. A low-priority service can be interrupted only by that promoted source. A high-priority service cannot be interrupted at all. When no source is promoted, the first service accepted blocks everything else until it returns.

The request latches live outside the block. When a service is accepted, the controller issues three things in the same cycle: a one-cycle start pulse, the winning source index and a clear strobe for that source's request latch. Requests that are held off stay pending. They compete again once a return strobe pops the blocking level. The nesting depth (0, 1 or 2) is visible on an output. The register contents can be read back.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `cfg_rd_o` is 0000, `depth_o` is 0, and `start_o` and `clr_o` are 0.
- R2: `cfg_rd_o` = {global enable, select code}. A write while the global enable is 0 loads bit 3 into the enable and bits 2..0 into the select code. A write while the global enable is 1 is ignored.
- R3: `ei_i` sets the global enable and `di_i` clears it. When both are asserted, `di_i` wins. Both take effect at the next clock edge.
- R4: A source can be serviced only when its request, its enable and the global enable were all 1 at the deciding edge. The start pulse appears after that same edge. In the same cycle, `clr_o` is one-hot at bit `start_idx_o`.
- R5: If several eligible requests arrive together, the promoted source wins. Promotion uses select codes 1..5, where code k selects source k-1. Without a promoted winner, the lowest-numbered source wins.
- R6: While one low-priority service runs, only the promoted source can start. It raises `depth_o` from 1 to 2. Other low-priority requests stay pending.
- R7: While a high-priority service runs, no source can start.
- R8: With select code 0, or the unused codes 6 and 7, the first accepted service blocks every other source until its return.
- R9: Each `reti_i` pulse lowers `depth_o` by one level. No service starts at the edge that samples `reti_i`. A request held off until then starts at the following edge.
- R10: `depth_o` never exceeds 2. Each start raises it by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 5 | Request flags, bit i for source i |
| en_i | input | 5 | Per-source enable flags |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 4 | Write data: bit 3 enable, bits 2..0 select code |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| reti_i | input | 1 | Return from the current service |
| start_o | output | 1 | One-cycle service start pulse |
| start_idx_o | output | 3 | Index of the source being started |
| clr_o | output | 5 | Request latch clear strobes |
| depth_o | output | 2 | Current nesting depth |
| cfg_rd_o | output | 4 | Register read-back |

## Verification
All results are registered once. A start, its index and its clear strobe appear right after the edge that samples the request. Register, enable and depth changes also appear right after the edge that samples their strobe. A request that was held off starts one edge after the return strobe, because the return edge itself never accepts anything. The bench drives every input on the falling edge and samples one nanosecond after the rising edge, so every check lands in the cycle the requirement names. A bench-side latch clears each request one edge after its clear strobe, just as an external flag would.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSRC_DFLT = 5;
  localparam int SELW_DFLT = 3;

  typedef enum logic [1:0] {
    LVL_IDLE = 2'd0,
    LVL_ONE  = 2'd1,
    LVL_TWO  = 2'd2
  } lvl_e;
endpackage

// File: rtl/irq_prio_reg.sv
module irq_prio_reg #(
  parameter int N_SRC = irq_nest_pkg::NSRC_DFLT,
  parameter int SEL_W = irq_nest_pkg::SELW_DFLT,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEL_W:0]   wdata,
  input  logic             ei,
  input  logic             di,
  output logic             ime,
  output logic [SEL_W-1:0] sel,
  output logic             hi_vld,
  output logic [IDX_W-1:0] hi_idx
);
  // a select code names a source only when it lies in 1..N_SRC
  function automatic logic code_names_src(input logic [SEL_W-1:0] c);
    return (c != '0) && (int'(c) <= N_SRC);
  endfunction

  function automatic logic [IDX_W-1:0] code_to_idx(input logic [SEL_W-1:0] c);
    logic [SEL_W-1:0] d;
    d = c - 1'b1;
    return d[IDX_W-1:0];
  endfunction

  logic wr_ok;
  assign wr_ok = wr && !ime;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime <= 1'b0;
      sel <= '0;
    end else begin
      if (wr_ok) sel <= wdata[SEL_W-1:0];
      if (di)         ime <= 1'b0;
      else if (ei)    ime <= 1'b1;
      else if (wr_ok) ime <= wdata[SEL_W];
    end
  end

  assign hi_vld = code_names_src(sel);
  assign hi_idx = code_to_idx(sel);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = irq_nest_pkg::NSRC_DFLT,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] elig,
  input  logic             hi_vld,
  input  logic [IDX_W-1:0] hi_idx,
  output logic             win_vld,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_is_hi
);
  // lowest set bit = highest default rank
  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_SRC-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic hi_req;
  assign hi_req = hi_vld && elig[hi_idx];

  always_comb begin
    win_vld = |elig;
    if (hi_req) win_idx = hi_idx;
    else        win_idx = lowest_set(elig);
    win_is_hi = hi_req;
  end
endmodule

// File: rtl/irq_level_trk.sv
module irq_level_trk
  import irq_nest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       push_blk,
  input  logic       pop,
  output logic [1:0] depth,
  output logic       blocked,
  output logic       open_hi
);
  lvl_e lvl;
  logic bot_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= LVL_IDLE;
      bot_blk <= 1'b0;
    end else if (pop) begin
      case (lvl)
        LVL_TWO: lvl <= LVL_ONE;
        LVL_ONE: begin
          lvl     <= LVL_IDLE;
          bot_blk <= 1'b0;
        end
        default: lvl <= LVL_IDLE;
      endcase
    end else if (push) begin
      case (lvl)
        LVL_IDLE: begin
          lvl     <= LVL_ONE;
          bot_blk <= push_blk;
        end
        LVL_ONE: lvl <= LVL_TWO;
        default: lvl <= lvl;
      endcase
    end
  end

  assign depth   = lvl;
  assign blocked = (lvl == LVL_TWO) || ((lvl == LVL_ONE) && bot_blk);
  assign open_hi = (lvl == LVL_ONE) && !bot_blk;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int N_SRC = irq_nest_pkg::NSRC_DFLT,
  parameter int SEL_W = irq_nest_pkg::SELW_DFLT,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             cfg_wr_i,
  input  logic [SEL_W:0]   cfg_wdata_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             reti_i,
  output logic             start_o,
  output logic [IDX_W-1:0] start_idx_o,
  output logic [N_SRC-1:0] clr_o,
  output logic [1:0]       depth_o,
  output logic [SEL_W:0]   cfg_rd_o
);
  function automatic logic [N_SRC-1:0] idx_onehot(input logic [IDX_W-1:0] i);
    logic [N_SRC-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  // named internal events (also used by the bound checker)
  logic             ime_w;
  logic [SEL_W-1:0] sel_w;
  logic             hi_vld_w;
  logic [IDX_W-1:0] hi_idx_w;
  logic             blocked_w;
  logic             open_hi_w;
  logic [N_SRC-1:0] allow_w;
  logic [N_SRC-1:0] elig_w;
  logic             win_vld_w;
  logic [IDX_W-1:0] win_idx_w;
  logic             win_hi_w;
  logic             accept_w;
  logic             push_blk_w;

  irq_prio_reg #(.N_SRC(N_SRC), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr_i),
    .wdata  (cfg_wdata_i),
    .ei     (ei_i),
    .di     (di_i),
    .ime    (ime_w),
    .sel    (sel_w),
    .hi_vld (hi_vld_w),
    .hi_idx (hi_idx_w)
  );

  irq_level_trk u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept_w),
    .push_blk (push_blk_w),
    .pop      (reti_i),
    .depth    (depth_o),
    .blocked  (blocked_w),
    .open_hi  (open_hi_w)
  );

  // which sources the current nesting state lets through
  always_comb begin
    allow_w = '0;
    if (depth_o == 2'd0)             allow_w = '1;
    else if (open_hi_w && hi_vld_w)  allow_w = idx_onehot(hi_idx_w);
  end

  // a source whose clear strobe is out is masked until its latch drops
  assign elig_w = req_i & en_i & ~clr_o & {N_SRC{ime_w}} & allow_w;

  irq_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .elig      (elig_w),
    .hi_vld    (hi_vld_w),
    .hi_idx    (hi_idx_w),
    .win_vld   (win_vld_w),
    .win_idx   (win_idx_w),
    .win_is_hi (win_hi_w)
  );

  assign accept_w   = win_vld_w && !reti_i;
  assign push_blk_w = !hi_vld_w || win_hi_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o     <= 1'b0;
      start_idx_o <= '0;
      clr_o       <= '0;
    end else begin
      start_o     <= accept_w;
      start_idx_o <= accept_w ? win_idx_w : start_idx_o;
      clr_o       <= accept_w ? idx_onehot(win_idx_w) : '0;
    end
  end

  assign cfg_rd_o = {ime_w, sel_w};
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int N_SRC = 5,
  parameter int SEL_W = 3,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req_i,
  input logic [N_SRC-1:0] en_i,
  input logic             reti_i,
  input logic             ime_w,
  input logic [SEL_W-1:0] sel_w,
  input logic             blocked_w,
  input logic             start_o,
  input logic [IDX_W-1:0] start_idx_o,
  input logic [N_SRC-1:0] clr_o,
  input logic [1:0]       depth_o
);
  AST_CLR_ONE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> ($countones(clr_o) == 1) && clr_o[start_idx_o]); // R4
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |-> (clr_o == '0)); // R4
  AST_START_NEEDS_IME: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(ime_w)); // R4
  AST_START_NEEDS_REQ_EN: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (($past(req_i & en_i) & clr_o) != '0)); // R4
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ime_w |=> (sel_w == $past(sel_w))); // R2
  AST_BLOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_w |=> !start_o); // R7
  AST_RETI_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> !start_o); // R9
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= 2'd2); // R10
  AST_PUSH_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (depth_o == $past(depth_o) + 2'd1)); // R10
endmodule

bind irq_nest_ctrl irq_nest_chk #(.N_SRC(N_SRC), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_irq_nest_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .en_i        (en_i),
  .reti_i      (reti_i),
  .ime_w       (ime_w),
  .sel_w       (sel_w),
  .blocked_w   (blocked_w),
  .start_o     (start_o),
  .start_idx_o (start_idx_o),
  .clr_o       (clr_o),
  .depth_o     (depth_o)
);

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] req_i, en_i;
  logic       cfg_wr_i;
  logic [3:0] cfg_wdata_i;
  logic       ei_i, di_i, reti_i;
  logic       start_o;
  logic [2:0] start_idx_o;
  logic [4:0] clr_o;
  logic [1:0] depth_o;
  logic [3:0] cfg_rd_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_nest_ctrl i_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_i(en_i),
    .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .ei_i(ei_i), .di_i(di_i),
    .reti_i(reti_i), .start_o(start_o), .start_idx_o(start_idx_o),
    .clr_o(clr_o), .depth_o(depth_o), .cfg_rd_o(cfg_rd_o)
  );

  // external request latches: a clear strobe drops the flag at the next edge
  always @(posedge clk) if (rst_n) req_i <= req_i & ~clr_o;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic raise(input logic [4:0] m);
    @(negedge clk); req_i = req_i | m;
    tick();
  endtask

  task automatic pulse_ei();
    @(negedge clk); ei_i = 1'b1; tick(); ei_i = 1'b0;
  endtask

  task automatic pulse_di();
    @(negedge clk); di_i = 1'b1; tick(); di_i = 1'b0;
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti_i = 1'b1; tick(); reti_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk); cfg_wr_i = 1'b1; cfg_wdata_i = d; tick(); cfg_wr_i = 1'b0;
  endtask

  task automatic cfg(input int sel);
    pulse_di();
    wr({1'b1, 3'(sel)});
  endtask

  // expected winner: promoted source first, else lowest set index
  function automatic int pick_exp(input int sel, input int m);
    if (sel >= 1 && sel <= 5 && ((m >> (sel - 1)) & 1) == 1) return sel - 1;
    for (int i = 0; i < 5; i++) if (((m >> i) & 1) == 1) return i;
    return -1;
  endfunction

  task automatic expect_start(input int idx, input int dep, input string tag);
    chk(start_o === 1'b1 && int'(start_idx_o) == idx, tag, start_o ? int'(start_idx_o) : -1, idx);
    chk(clr_o === 5'(1 << idx), tag, int'(clr_o), 1 << idx);
    chk(int'(depth_o) == dep, tag, int'(depth_o), dep);
  endtask

  task automatic expect_quiet(input string tag);
    chk(start_o === 1'b0, tag, int'(start_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = '0; en_i = '0; cfg_wr_i = 1'b0; cfg_wdata_i = '0;
    ei_i = 1'b0; di_i = 1'b0; reti_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(cfg_rd_o == 4'b0000, "R1 cfg", int'(cfg_rd_o), 0);
    chk(depth_o == 2'd0, "R1 depth", int'(depth_o), 0);
    chk(start_o == 1'b0 && clr_o == '0, "R1 start/clr", int'(clr_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 writes, all eight codes with enable kept low
    for (int c = 0; c < 8; c++) begin
      wr(4'(c));
      chk(cfg_rd_o == 4'(c), "R2 write", int'(cfg_rd_o), c);
    end
    wr(4'b1011);
    chk(cfg_rd_o == 4'b1011, "R2 write sets enable", int'(cfg_rd_o), 11);
    wr(4'b0010);
    chk(cfg_rd_o == 4'b1011, "R2 write ignored while enabled", int'(cfg_rd_o), 11);

    // R3 enable strobes
    pulse_di();
    chk(cfg_rd_o == 4'b0011, "R3 di", int'(cfg_rd_o), 3);
    pulse_ei();
    chk(cfg_rd_o == 4'b1011, "R3 ei", int'(cfg_rd_o), 11);
    @(negedge clk); ei_i = 1'b1; di_i = 1'b1; tick(); ei_i = 1'b0; di_i = 1'b0;
    chk(cfg_rd_o == 4'b0011, "R3 di wins", int'(cfg_rd_o), 3);

    // R4 global enable gates service
    wr(4'b0000);
    en_i = 5'b11111;
    raise(5'b01000);
    expect_quiet("R4 enable low");
    tick();
    expect_quiet("R4 enable low");
    pulse_ei();
    expect_quiet("R4 enable just set");
    tick();
    expect_start(3, 1, "R4 start after ei");
    tick();
    pulse_reti();

    // R5/R9 sweep: every select code 0..5, every request subset
    for (int s = 0; s < 6; s++) begin
      for (int m = 1; m < 32; m++) begin
        int rem;
        cfg(s);
        en_i = 5'b11111;
        rem = m;
        raise(5'(m));
        while (rem != 0) begin
          int w;
          w = pick_exp(s, rem);
          expect_start(w, 1, "R5 arbitration order");
          rem = rem & ~(1 << w);
          tick();
          expect_quiet("R6 no low preemption");
          pulse_reti();
          chk(depth_o == 2'd0 && start_o == 1'b0, "R9 return edge", int'(depth_o), 0);
          if (rem != 0) tick();
        end
      end
    end

    // R4 per-source enable sweep with all requests raised
    cfg(0);
    for (int e = 0; e < 32; e++) begin
      en_i = 5'(e);
      raise(5'b11111);
      if (e == 0) expect_quiet("R4 all disabled");
      else expect_start(pick_exp(0, e), 1, "R4 enable mask");
      @(negedge clk); req_i = '0;
      tick();
      if (e != 0) pulse_reti();
    end
    en_i = 5'b11111;

    // R6: low service preempted only by the promoted source 2
    cfg(3);
    raise(5'b10000);
    expect_start(4, 1, "R6 low start");
    raise(5'b00001);
    expect_quiet("R6 low blocks low");
    tick();
    expect_quiet("R6 low blocks low");
    raise(5'b00100);
    expect_start(2, 2, "R6 high preempts");
    tick();
    expect_quiet("R7 high not preempted");
    pulse_reti();
    chk(depth_o == 2'd1, "R9 pop to one", int'(depth_o), 1);
    tick();
    expect_quiet("R6 pending low held");
    pulse_reti();
    chk(depth_o == 2'd0, "R9 pop to idle", int'(depth_o), 0);
    tick();
    expect_start(0, 1, "R9 replay after return");
    tick();
    pulse_reti();

    // R7: promoted source blocks everything
    cfg(5);
    raise(5'b10000);
    expect_start(4, 1, "R7 high start");
    raise(5'b00001);
    expect_quiet("R7 high blocks");
    tick();
    expect_quiet("R7 high blocks");
    pulse_reti();
    tick();
    expect_start(0, 1, "R9 replay after high");
    tick();
    pulse_reti();

    // R8: unused codes 6 and 7 behave as 0
    for (int c = 6; c < 8; c++) begin
      cfg(c);
      raise(5'b10000);
      expect_start(4, 1, "R8 first start");
      raise(5'b00001);
      expect_quiet("R8 first blocks");
      tick();
      expect_quiet("R8 first blocks");
      pulse_reti();
      tick();
      expect_start(0, 1, "R8 replay");
      tick();
      pulse_reti();
      chk(depth_o == 2'd0, "R10 depth back to idle", int'(depth_o), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule